// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets a clocked requester inside the chip read and write an external asynchronous static RAM of 131,072 bytes. The requester raises `req_i` with a direction flag, a 17-bit byte address and write data. It keeps them steady until `ready_o` pulses. On that pulse, a read also returns the byte it fetched on `rdata_o`.

On the memory side the controller drives the three active-low strobes (chip select, output enable, write strobe) and the address. It also drives the 8-bit data bus, which is split into an outgoing value, an incoming value and a driver enable, so that a tri-state pad can be built at the chip edge. The number of clock cycles the read strobes stay low, and the number the write strobe stays low, are parameters. They are chosen so that they cover the RAM's 10 ns access time at the clock in use.

A write has four phases. First a setup cycle, then the write strobe pulse, then a hold cycle in which the chip select and the write strobe are already high again but the controller still drives the bus. Last comes the ready cycle, in which the driver is off. A write that follows a read gets one extra cycle with every strobe high before it starts, so that the RAM can let go of the bus first.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `mem_ce_no`, `mem_oe_no` and `mem_we_no` are 1, `mem_dq_oe_o` is 0 and `ready_o` is 0.
- R2: A write (`we_i`=1) takes these cycles after the accepting edge:
  - one setup cycle with chip select low, write strobe high and the driver on;
  - WR_WAIT cycles with the write strobe low;
  - one hold cycle with the driver still on;
  - the ready cycle, with the driver off.
  `ready_o` therefore rises WR_WAIT+3 cycles after acceptance, and the addressed byte then holds the write data.
- R3: At the end of the write pulse, `mem_ce_no` and `mem_we_no` rise on the same clock edge.
- R4: `mem_oe_no` stays high through every cycle of a write, and `mem_oe_no` and `mem_we_no` are never low together.
- R5: A read (`we_i`=0) holds the chip select and output enable low, with the write strobe high, for RD_WAIT cycles. The bus is sampled on the edge that ends the last of these cycles. `ready_o` rises RD_WAIT+1 cycles after acceptance, with that byte on `rdata_o`.
- R6: The bus driver is never on while the output enable is low, and it is off in the cycle that follows any cycle with the output enable low.
- R7: When a write is accepted and the most recently completed access was a read, one cycle with all strobes high and the driver off comes first. That write's ready is then WR_WAIT+4 cycles after acceptance.
- R8: `ready_o` is high for exactly one cycle per access.
- R9: A request is accepted only when the controller is idle and `ready_o` is low. Changes to `addr_i`, `wdata_i` or `req_i` while an access runs, or during its ready cycle, neither alter nor start an access.
- R10: While the write strobe is low, the address and the outgoing data do not change, and the address stays equal to the accepted address whenever the chip select is low or the driver is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with ready |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write strobe, active low |
| mem_addr_o | output | 17 | Memory address |
| mem_dq_o | output | 8 | Outgoing bus data |
| mem_dq_i | input | 8 | Incoming bus data |
| mem_dq_oe_o | output | 1 | Bus driver enable |

## Verification
The hardest cases are a write accepted right after a read, and a request left high through the ready cycle. Neither comes from a requester that lets the bus idle between accesses.

The bench issues its next request as soon as the previous ready has been seen, so a write directly behind a read must show the extra all-high cycle. One scenario keeps `req_i` high across the ready edge and then checks that no new access starts. Another changes the address and data partway through a write and reads both locations back. Each access records the strobes, the driver enable and the address on every cycle, so the setup, pulse, hold and turnaround phases are checked cycle by cycle. A bench RAM model flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPW  = 3'd3,
    ST_WHD  = 3'd4,
    ST_RD   = 3'd5
  } sram_st_e;
endpackage

// File: rtl/sram_ctrl_wait.sv
module sram_ctrl_wait #(
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic is_rd_i,
  output logic last_o
);
  localparam int MAX_WAIT = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_WAIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == (is_rd_i ? RD_LAST : WR_LAST));
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     we_i,
  input  logic     ready_i,
  output sram_st_e state_o,
  output logic     accept_o,
  output logic     rd_done_o,
  output logic     wr_done_o
);
  sram_st_e st_q, st_d;
  logic     last_rd_q;
  logic     clr, inc, last;

  sram_ctrl_wait #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .inc_i   (inc),
    .is_rd_i (st_q == ST_RD),
    .last_o  (last)
  );

  // ready cycle blocks acceptance so a held request is not re-taken
  assign accept_o = req_i && (st_q == ST_IDLE) && !ready_i;

  always_comb begin
    st_d      = st_q;
    clr       = 1'b0;
    inc       = 1'b0;
    rd_done_o = 1'b0;
    wr_done_o = 1'b0;
    case (st_q)
      ST_IDLE: if (accept_o) begin
        if (!we_i) begin
          st_d = ST_RD;
          clr  = 1'b1;
        end else if (last_rd_q) begin
          st_d = ST_TURN;
        end else begin
          st_d = ST_WSU;
        end
      end
      ST_TURN: st_d = ST_WSU;
      ST_WSU: begin
        st_d = ST_WPW;
        clr  = 1'b1;
      end
      ST_WPW: if (last) st_d = ST_WHD;
              else      inc  = 1'b1;
      ST_WHD: begin
        st_d      = ST_IDLE;
        wr_done_o = 1'b1;
      end
      ST_RD: if (last) begin
        st_d      = ST_IDLE;
        rd_done_o = 1'b1;
      end else begin
        inc = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (rd_done_o)          last_rd_q <= 1'b1;
      else if (st_q == ST_WSU) last_rd_q <= 1'b0;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sram_ctrl_strobe.sv
module sram_ctrl_strobe
  import sram_ctrl_pkg::*;
(
  input  sram_st_e state_i,
  output logic     ce_no,
  output logic     oe_no,
  output logic     we_no,
  output logic     dq_oe_o
);
  // single-level decode of a registered state
  always_comb begin
    ce_no   = 1'b1;
    oe_no   = 1'b1;
    we_no   = 1'b1;
    dq_oe_o = 1'b0;
    case (state_i)
      ST_WSU: begin
        ce_no   = 1'b0;
        dq_oe_o = 1'b1;
      end
      ST_WPW: begin
        ce_no   = 1'b0;
        we_no   = 1'b0;
        dq_oe_o = 1'b1;
      end
      ST_WHD: dq_oe_o = 1'b1;
      ST_RD: begin
        ce_no = 1'b0;
        oe_no = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              rd_done_i,
  input  logic              wr_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
      rdata_o    <= '0;
      ready_o    <= 1'b0;
    end else begin
      if (accept_i) begin
        mem_addr_o <= addr_i;
        mem_dq_o   <= wdata_i;
      end
      if (rd_done_i) rdata_o <= mem_dq_i;
      ready_o <= rd_done_i | wr_done_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  sram_st_e state;
  logic     accept, rd_done, wr_done;

  sram_ctrl_fsm #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .ready_i   (ready_o),
    .state_o   (state),
    .accept_o  (accept),
    .rd_done_o (rd_done),
    .wr_done_o (wr_done)
  );

  sram_ctrl_strobe u_strobe (
    .state_i (state),
    .ce_no   (mem_ce_no),
    .oe_no   (mem_oe_no),
    .we_no   (mem_we_no),
    .dq_oe_o (mem_dq_oe_o)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .rd_done_i  (rd_done),
    .wr_done_i  (wr_done),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o),
    .ready_o    (ready_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_dq_o
);
  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));

  assert_no_contend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));

  assert_turn_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |=> !mem_dq_oe_o);

  assert_we_needs_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_dq_oe_o));

  assert_joint_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> $rose(mem_ce_no));

  assert_hold_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_stable_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |=> ($stable(mem_addr_o) && $stable(mem_dq_o)));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .mem_ce_no   (mem_ce_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_o    (mem_dq_o)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int RD_WAIT = 2;
  localparam int WR_WAIT = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [16:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o;
  logic [7:0]  rdata_o;
  logic        mem_ce_no, mem_oe_no, mem_we_no, mem_dq_oe_o;
  logic [16:0] mem_addr_o;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int checks = 0;
  int errors = 0;
  int contend = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sram_ctrl #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe_o(mem_dq_oe_o)
  );

  // small RAM model: 256 bytes indexed by {addr[16], addr[6:0]}
  logic [7:0] ram [256];
  logic       ram_drv;
  assign ram_drv  = !mem_ce_no && !mem_oe_no && mem_we_no;
  assign mem_dq_i = ram_drv ? ram[{mem_addr_o[16], mem_addr_o[6:0]}] : 8'hEE;

  always @(negedge clk_i) begin
    if (rst_ni && !mem_ce_no && !mem_we_no && mem_dq_oe_o)
      ram[{mem_addr_o[16], mem_addr_o[6:0]}] <= mem_dq_o;
    if (rst_ni && ram_drv && mem_dq_oe_o) contend++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access; records strobes each cycle and checks the phases
  task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d,
                        input bit exp_turn, input logic [7:0] exp_q,
                        input int chg_at, input bit hold_req);
    logic tce [32], toe [32], twe [32], tdo [32];
    logic [16:0] tad [32];
    int lat = 0;
    int o, nlow;
    @(negedge clk_i);
    we_i = w; addr_i = a; wdata_i = d; req_i = 1'b1;
    forever begin
      @(negedge clk_i);
      tce[lat] = mem_ce_no; toe[lat] = mem_oe_no; twe[lat] = mem_we_no;
      tdo[lat] = mem_dq_oe_o; tad[lat] = mem_addr_o;
      lat++;
      if (lat == chg_at) begin
        addr_i = a ^ 17'h0007F; wdata_i = ~d;
      end
      if (ready_o || lat >= 30) break;
    end
    if (w) begin
      o = exp_turn ? 1 : 0;
      chk(lat == WR_WAIT + 3 + o, exp_turn ? "R7 write latency" : "R2 write latency",
          lat, WR_WAIT + 3 + o);
      if (exp_turn)
        chk(tce[0] && toe[0] && twe[0] && !tdo[0], "R7 turnaround idle",
            {tce[0], toe[0], twe[0], tdo[0]}, 4'b1110);
      chk(!tce[o] && twe[o] && tdo[o], "R2 setup cycle",
          {tce[o], twe[o], tdo[o]}, 3'b011);
      nlow = 0;
      for (int i = 0; i < lat; i++) if (!twe[i]) nlow++;
      chk(nlow == WR_WAIT && !twe[o+1] && !twe[o+WR_WAIT], "R2 pulse width", nlow, WR_WAIT);
      chk(tce[o+WR_WAIT+1] && twe[o+WR_WAIT+1] && tdo[o+WR_WAIT+1], "R3 joint release hold",
          {tce[o+WR_WAIT+1], twe[o+WR_WAIT+1], tdo[o+WR_WAIT+1]}, 3'b111);
      chk(!tdo[lat-1] && tce[lat-1], "R2 driver off at ready", tdo[lat-1], 0);
      nlow = 0;
      for (int i = 0; i < lat; i++) if (!toe[i]) nlow++;
      chk(nlow == 0, "R4 oe high in write", nlow, 0);
    end else begin
      chk(lat == RD_WAIT + 1, "R5 read latency", lat, RD_WAIT + 1);
      nlow = 0;
      for (int i = 0; i < lat; i++) begin
        if (!toe[i] && !tce[i] && twe[i]) nlow++;
        if (tdo[i]) nlow += 100;
      end
      chk(nlow == RD_WAIT, "R5 R6 read strobes", nlow, RD_WAIT);
      chk(rdata_o == exp_q, "R5 read data", rdata_o, exp_q);
    end
    nlow = 0;
    for (int i = 0; i < lat; i++) if ((!tce[i] || tdo[i]) && tad[i] != a) nlow++;
    chk(nlow == 0, "R9 R10 address held", nlow, 0);
    if (!hold_req) req_i = 1'b0;
    @(negedge clk_i);
    chk(!ready_o, "R8 ready one cycle", ready_o, 0);
    if (hold_req) begin
      chk(mem_ce_no && !mem_dq_oe_o, "R9 held request ignored", mem_ce_no, 1);
      req_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(mem_ce_no && mem_oe_no && mem_we_no, "R1 strobes high",
        {mem_ce_no, mem_oe_no, mem_we_no}, 3'b111);
    chk(!mem_dq_oe_o && !ready_o, "R1 driver off ready low", {mem_dq_oe_o, ready_o}, 0);
  endtask

  task automatic t_basic();
    access(1, 17'h00000, 8'hA5, 0, 8'h00, -1, 0);
    access(0, 17'h00000, 8'h00, 0, 8'hA5, -1, 0);
    access(1, 17'h1FFFF, 8'h3C, 1, 8'h00, -1, 0);
    access(0, 17'h1FFFF, 8'h00, 0, 8'h3C, -1, 0);
    access(0, 17'h00000, 8'h00, 0, 8'hA5, -1, 0);
  endtask

  task automatic t_patterns();
    access(1, 17'h00055, 8'hFF, 1, 8'h00, -1, 0);
    access(1, 17'h10023, 8'h00, 0, 8'h00, -1, 0);
    access(1, 17'h0002A, 8'h11, 0, 8'h00, -1, 0);
    access(0, 17'h00055, 8'h00, 0, 8'hFF, -1, 0);
    access(0, 17'h10023, 8'h00, 0, 8'h00, -1, 0);
  endtask

  task automatic t_busy_change();
    // address/data flip mid-write to 0x0002A / ~0x5A; must be ignored
    access(1, 17'h00055, 8'h5A, 1, 8'h00, 2, 0);
    access(0, 17'h00055, 8'h00, 0, 8'h5A, -1, 0);
    access(0, 17'h0002A, 8'h00, 0, 8'h11, -1, 0);
  endtask

  task automatic t_hold_req();
    access(1, 17'h10023, 8'h77, 1, 8'h00, -1, 1);
    access(0, 17'h10023, 8'h00, 0, 8'h77, -1, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_basic();
    t_patterns();
    t_busy_change();
    t_hold_req();
    chk(contend == 0, "R6 no bus contention", contend, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule